// File: doc/BRIEF.md
# Protected-Mode Segment Register Load Checker

This block validates a selector that is being loaded into one of the data segment registers or the stack segment register while the processor runs under segment protection. The requester presents the target register, the 16-bit selector, the attribute byte of the descriptor it points to, the current descriptor table limit, the current privilege level and a 64-bit-mode flag. The descriptor fetch itself happens upstream; this unit only judges the result. One cycle after it captures the request, the unit either writes the selector and attribute into the chosen register, or reports a one-hot fault and an error code and leaves every register unchanged.

A successful stack segment load also raises an interrupt-shadow flag. That flag masks interrupts at the next instruction boundary and drops when that instruction retires or when an exception is delivered.

Control is a two-state machine. `ST_IDLE` waits for a request. The transition `ST_IDLE -> ST_EVAL` is taken when `load_req` is high and captures all request inputs. `ST_EVAL` judges the captured request. The transition `ST_EVAL -> ST_IDLE` is taken unconditionally and registers the verdict onto `done`, `fault` and `err_code`, and commits the selector and attribute if there is no fault.

Top module: `segld_top`

## Requirements
- R1: After reset, `done`, `fault` and `irq_inhibit` are 0, and every selector and attribute reads back as 0.
- R2: Target codes are DS=0, ES=1, FS=2, GS=3 and SS=4. A request is captured only in `ST_IDLE`. Its verdict appears as a one-cycle `done` pulse after the second rising edge from capture. A request held during `ST_EVAL` is ignored.
- R3: The fault vector is one-hot or zero, with bit0=GP, bit1=SS fault, bit2=NP and bit3=UD. `err_code` is the selector with bits [1:0] cleared, except that it is 0 for UD and for a null SS load.
- R4: A selector whose bits [15:2] are zero is null. A null load into SS outside 64-bit mode gives GP with error code 0.
- R5: The attribute byte is [7]=present, [6:5]=DPL, [4]=code/data (not system), [3]=code, [2]=conforming (code), [1]=readable (code) or writable (data). A non-null SS load gives GP in any of these cases: the selector index*8+7 exceeds the table limit, the RPL differs from the CPL, the DPL differs from the CPL, or the segment is not a writable data segment.
- R6: A non-null SS load that passes R5 but whose present bit is 0 gives the SS fault.
- R7: A null load into DS, ES, FS or GS gives no fault. It writes the selector and an all-zero attribute.
- R8: A non-null DS/ES/FS/GS load gives GP in any of these cases: the index is over the limit, the descriptor is a system one, the descriptor is execute-only code, or the segment is data or nonconforming code and either RPL > DPL or CPL > DPL.
- R9: A DS/ES/FS/GS load whose present bit is 0 gives NP, but only when no GP condition holds. GP takes priority.
- R10: The selector and attribute are written only when there is no fault. A fault leaves every register as it was.
- R11: In 64-bit mode only FS and GS may be loaded. A DS, ES or SS target gives UD. Target codes 5 to 7 give UD in every mode.
- R12: A committed SS load sets `irq_inhibit`. `insn_retire` or `exc_taken` clears it. Setting wins over clearing in the same cycle, and a failed SS load does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Load request, sampled in idle |
| load_dst | input | 3 | Target register code |
| load_sel | input | 16 | Selector to load |
| load_attr | input | 8 | Descriptor attribute byte |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit mode active |
| insn_retire | input | 1 | An instruction retired this cycle |
| exc_taken | input | 1 | An exception was delivered this cycle |
| rd_dst | input | 3 | Read-back register select |
| done | output | 1 | Verdict valid pulse |
| fault | output | 4 | One-hot fault vector |
| err_code | output | 16 | Error code for the fault |
| rd_sel | output | 16 | Selector of the read-back register |
| rd_attr | output | 8 | Attribute of the read-back register |
| irq_inhibit | output | 1 | Interrupt shadow after an SS load |

## Verification
The assertions check these rules on every cycle:
- the fault vector stays one-hot;
- a fault only appears with `done`;
- `done` lasts one cycle and trails a request by two edges;
- error codes have their low bits clear, and UD carries a zero code;
- the interrupt shadow rises only on a clean SS commit and falls only on a retire or an exception.

Only the bench scenarios can show which fault each descriptor, privilege and limit combination selects. The same holds for GP outranking NP, the null-selector paths, the 64-bit-mode restrictions, that a faulting load leaves the registers intact, and that a request overlapping an evaluation is dropped.

// File: rtl/segld_pkg.sv
package segld_pkg;
    localparam int SEL_W   = 16;
    localparam int ATTR_W  = 8;
    localparam int NUM_SEG = 5;
    localparam int IDX_W   = $clog2(NUM_SEG);
    localparam int FLT_W   = 4;
    localparam int PL_W    = 2;

    localparam int F_GP = 0;
    localparam int F_SS = 1;
    localparam int F_NP = 2;
    localparam int F_UD = 3;

    localparam int A_P    = 7;
    localparam int A_DPLH = 6;
    localparam int A_DPLL = 5;
    localparam int A_S    = 4;
    localparam int A_CODE = 3;
    localparam int A_CONF = 2;
    localparam int A_RW   = 1;

    typedef enum logic [IDX_W-1:0] {
        SEG_DS = 3'd0,
        SEG_ES = 3'd1,
        SEG_FS = 3'd2,
        SEG_GS = 3'd3,
        SEG_SS = 3'd4
    } seg_e;

    typedef enum logic {
        ST_IDLE,
        ST_EVAL
    } fsm_e;
endpackage

// File: rtl/segld_rules.sv
module segld_rules
    import segld_pkg::*;
(
    input  logic [IDX_W-1:0]  dst,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ATTR_W-1:0] attr,
    input  logic [SEL_W-1:0]  limit,
    input  logic [PL_W-1:0]   cpl,
    input  logic              long_mode,
    output logic [FLT_W-1:0]  fault,
    output logic [SEL_W-1:0]  err,
    output logic [ATTR_W-1:0] wr_attr
);
    logic            is_null;
    logic            over_lim;
    logic [PL_W-1:0] rpl;
    logic [PL_W-1:0] dpl;
    logic [SEL_W-1:0] err_sel;
    logic            ss_bad;
    logic            ds_bad;
    logic            dst_ok;

    always_comb begin
        is_null  = (sel[SEL_W-1:2] == '0);
        over_lim = ({sel[SEL_W-1:3], 3'b111} > limit);
        rpl      = sel[1:0];
        dpl      = attr[A_DPLH:A_DPLL];
        err_sel  = {sel[SEL_W-1:2], 2'b00};

        ss_bad = over_lim || (rpl != cpl) || (dpl != cpl) ||
                 !(attr[A_S] && !attr[A_CODE] && attr[A_RW]);

        ds_bad = over_lim || !attr[A_S] ||
                 (attr[A_CODE] && !attr[A_RW]) ||
                 ((!attr[A_CODE] || !attr[A_CONF]) && ((rpl > dpl) || (cpl > dpl)));

        dst_ok = (dst <= SEG_SS) &&
                 (!long_mode || dst == SEG_FS || dst == SEG_GS);
    end

    always_comb begin
        fault   = '0;
        err     = '0;
        wr_attr = attr;
        if (!dst_ok) begin
            fault[F_UD] = 1'b1;
        end else if (dst == SEG_SS) begin
            if (is_null) begin
                fault[F_GP] = 1'b1;
            end else if (ss_bad) begin
                fault[F_GP] = 1'b1;
                err         = err_sel;
            end else if (!attr[A_P]) begin
                fault[F_SS] = 1'b1;
                err         = err_sel;
            end
        end else begin
            if (is_null) begin
                wr_attr = '0;
            end else if (ds_bad) begin
                fault[F_GP] = 1'b1;
                err         = err_sel;
            end else if (!attr[A_P]) begin
                fault[F_NP] = 1'b1;
                err         = err_sel;
            end
        end
    end
endmodule

// File: rtl/segld_regs.sv
module segld_regs
    import segld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ATTR_W-1:0] rd_attr
);
    logic [SEL_W-1:0]  vis_q  [NUM_SEG];
    logic [ATTR_W-1:0] hid_q  [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vis_q[g] <= '0;
                hid_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vis_q[g] <= wr_sel;
                hid_q[g] <= wr_attr;
            end
        end
    end

    always_comb begin
        rd_sel  = '0;
        rd_attr = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_sel  = vis_q[i];
                rd_attr = hid_q[i];
            end
        end
    end
endmodule

// File: rtl/segld_shadow.sv
module segld_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/segld_top.sv
module segld_top
    import segld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [IDX_W-1:0]  load_dst,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [ATTR_W-1:0] load_attr,
    input  logic [SEL_W-1:0]  tbl_limit,
    input  logic [PL_W-1:0]   cpl,
    input  logic              long_mode,
    input  logic              insn_retire,
    input  logic              exc_taken,
    input  logic [IDX_W-1:0]  rd_dst,
    output logic              done,
    output logic [FLT_W-1:0]  fault,
    output logic [SEL_W-1:0]  err_code,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ATTR_W-1:0] rd_attr,
    output logic              irq_inhibit
);
    fsm_e              state_q, state_d;
    logic [IDX_W-1:0]  cap_dst;
    logic [SEL_W-1:0]  cap_sel;
    logic [ATTR_W-1:0] cap_attr;
    logic [SEL_W-1:0]  cap_limit;
    logic [PL_W-1:0]   cap_cpl;
    logic              cap_lm;

    logic [FLT_W-1:0]  chk_fault;
    logic [SEL_W-1:0]  chk_err;
    logic [ATTR_W-1:0] chk_attr;
    logic              commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_req) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_dst   <= '0;
            cap_sel   <= '0;
            cap_attr  <= '0;
            cap_limit <= '0;
            cap_cpl   <= '0;
            cap_lm    <= 1'b0;
        end else if (state_q == ST_IDLE && load_req) begin
            cap_dst   <= load_dst;
            cap_sel   <= load_sel;
            cap_attr  <= load_attr;
            cap_limit <= tbl_limit;
            cap_cpl   <= cpl;
            cap_lm    <= long_mode;
        end
    end

    segld_rules u_rules (
        .dst       (cap_dst),
        .sel       (cap_sel),
        .attr      (cap_attr),
        .limit     (cap_limit),
        .cpl       (cap_cpl),
        .long_mode (cap_lm),
        .fault     (chk_fault),
        .err       (chk_err),
        .wr_attr   (chk_attr)
    );

    assign commit = (state_q == ST_EVAL) && (chk_fault == '0);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= '0;
            err_code <= '0;
        end else begin
            done     <= (state_q == ST_EVAL);
            fault    <= (state_q == ST_EVAL) ? chk_fault : '0;
            err_code <= (state_q == ST_EVAL) ? chk_err   : '0;
        end
    end

    segld_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (cap_dst),
        .wr_sel  (cap_sel),
        .wr_attr (chk_attr),
        .rd_idx  (rd_dst),
        .rd_sel  (rd_sel),
        .rd_attr (rd_attr)
    );

    segld_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (commit && cap_dst == SEG_SS),
        .clr   (insn_retire || exc_taken),
        .flag  (irq_inhibit)
    );
endmodule

// File: rtl/segld_top_chk.sv
module segld_top_chk
    import segld_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_req,
    input logic             done,
    input logic [FLT_W-1:0] fault,
    input logic [SEL_W-1:0] err_code,
    input logic             irq_inhibit,
    input logic             insn_retire,
    input logic             exc_taken,
    input logic [IDX_W-1:0] cap_dst
);
    p_fault_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault));

    p_fault_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault != '0) |-> done);

    p_err_low_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault != '0) |-> (err_code[1:0] == 2'b00));

    p_ud_zero_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault[F_UD] |-> (err_code == '0));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(load_req, 2));

    p_shadow_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_inhibit) |-> (done && fault == '0 && cap_dst == SEG_SS));

    p_shadow_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_inhibit) |-> $past(insn_retire || exc_taken));
endmodule

bind segld_top segld_top_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_req    (load_req),
    .done        (done),
    .fault       (fault),
    .err_code    (err_code),
    .irq_inhibit (irq_inhibit),
    .insn_retire (insn_retire),
    .exc_taken   (exc_taken),
    .cap_dst     (cap_dst)
);

// File: tb/segld_top_tb.sv
module segld_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic [2:0]  load_dst = '0;
    logic [15:0] load_sel = '0;
    logic [7:0]  load_attr = '0;
    logic [15:0] tbl_limit = 16'h00FF;
    logic [1:0]  cpl = '0;
    logic        long_mode = 1'b0;
    logic        insn_retire = 1'b0;
    logic        exc_taken = 1'b0;
    logic [2:0]  rd_dst = '0;
    logic        done;
    logic [3:0]  fault;
    logic [15:0] err_code;
    logic [15:0] rd_sel;
    logic [7:0]  rd_attr;
    logic        irq_inhibit;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct packed {
        logic [2:0]  dst;
        logic [3:0]  flt;
        logic [15:0] err;
    } item_t;

    item_t q_item[$];
    string q_tag[$];
    logic [15:0] m_sel  [5];
    logic [7:0]  m_attr [5];

    segld_top u_dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_dst(load_dst),
        .load_sel(load_sel), .load_attr(load_attr), .tbl_limit(tbl_limit),
        .cpl(cpl), .long_mode(long_mode), .insn_retire(insn_retire),
        .exc_taken(exc_taken), .rd_dst(rd_dst), .done(done), .fault(fault),
        .err_code(err_code), .rd_sel(rd_sel), .rd_attr(rd_attr),
        .irq_inhibit(irq_inhibit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected verdict from the requirements: GP=1, SSF=2, NP=4, UD=8
    task automatic predict(input logic [2:0] d, input logic [15:0] s, input logic [7:0] a,
                           output logic [3:0] f, output logic [15:0] e, output logic [7:0] wa);
        logic nul, ovr, ssok, dsbad;
        logic [1:0] r, dp;
        nul = (s[15:2] == 0);
        ovr = ({s[15:3], 3'b111} > tbl_limit);
        r = s[1:0]; dp = a[6:5];
        f = 4'h0; e = 16'h0; wa = a;
        ssok = a[4] && !a[3] && a[1] && !ovr && r == cpl && dp == cpl;
        dsbad = ovr || !a[4] || (a[3] && !a[1]) ||
                ((!a[3] || !a[2]) && (r > dp || cpl > dp));
        if (d > 3'd4 || (long_mode && d != 3'd2 && d != 3'd3)) f = 4'h8;
        else if (d == 3'd4) begin
            if (nul) f = 4'h1;
            else if (!ssok) begin f = 4'h1; e = {s[15:2], 2'b00}; end
            else if (!a[7]) begin f = 4'h2; e = {s[15:2], 2'b00}; end
        end else begin
            if (nul) wa = 8'h00;
            else if (dsbad) begin f = 4'h1; e = {s[15:2], 2'b00}; end
            else if (!a[7]) begin f = 4'h4; e = {s[15:2], 2'b00}; end
        end
    endtask

    task automatic issue(string tag, logic [2:0] d, logic [15:0] s, logic [7:0] a);
        item_t it;
        logic [7:0] wa;
        predict(d, s, a, it.flt, it.err, wa);
        it.dst = d;
        if (it.flt == 0) begin m_sel[d] = s; m_attr[d] = wa; end
        q_item.push_back(it);
        q_tag.push_back(tag);
        @(negedge clk);
        load_dst = d; load_sel = s; load_attr = a; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (q_item.size() == 0) begin
                    check("R2 unexpected done", 32'(done), 32'd0);
                end else begin
                    item_t it;
                    string tg;
                    it = q_item.pop_front();
                    tg = q_tag.pop_front();
                    check({tg, " fault"}, 32'(fault), 32'(it.flt));
                    check({tg, " err"}, 32'(err_code), 32'(it.err));
                    if (it.dst < 3'd5) begin
                        rd_dst = it.dst;
                        #1;
                        check({tg, " R10 sel"}, 32'(rd_sel), 32'(m_sel[it.dst]));
                        check({tg, " R10 attr"}, 32'(rd_attr), 32'(m_attr[it.dst]));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin m_sel[i] = '0; m_attr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", 32'(done), 0);
        check("R1 fault", 32'(fault), 0);
        check("R1 inhibit", 32'(irq_inhibit), 0);
        for (int i = 0; i < 5; i++) begin
            rd_dst = 3'(i); #1;
            check("R1 sel", 32'(rd_sel), 0);
            check("R1 attr", 32'(rd_attr), 0);
        end

        cpl = 2'd0;
        issue("R10 DS data ok",        3'd0, 16'h0010, 8'h93);
        issue("R8 ES readable code",   3'd1, 16'h0018, 8'h9A);
        cpl = 2'd3;
        issue("R8 FS conforming code", 3'd2, 16'h0023, 8'h9E);
        issue("R8 DS data cpl>dpl",    3'd0, 16'h0020, 8'h93);
        cpl = 2'd0;
        issue("R8 DS data rpl>dpl",    3'd0, 16'h0022, 8'hB3);
        issue("R8 GS exec-only code",  3'd3, 16'h0028, 8'h98);
        issue("R8 ES system desc",     3'd1, 16'h0030, 8'h82);
        issue("R8 DS over limit",      3'd0, 16'h0100, 8'h93);
        issue("R8 DS at limit edge",   3'd0, 16'h00F8, 8'h93);
        issue("R9 DS not present",     3'd0, 16'h0038, 8'h13);
        issue("R9 GP beats NP",        3'd1, 16'h003B, 8'h13);
        issue("R7 GS null",            3'd3, 16'h0002, 8'h9A);
        issue("R4 SS null",            3'd4, 16'h0003, 8'h93);
        issue("R5 SS rpl!=cpl",        3'd4, 16'h0041, 8'h93);
        issue("R5 SS dpl!=cpl",        3'd4, 16'h0040, 8'hB3);
        issue("R5 SS read-only",       3'd4, 16'h0040, 8'h91);
        issue("R5 SS code",            3'd4, 16'h0040, 8'h9B);
        check("R12 no set on fault", 32'(irq_inhibit), 0);
        issue("R6 SS not present",     3'd4, 16'h0048, 8'h13);
        issue("R11 bad dst code",      3'd6, 16'h0010, 8'h93);

        issue("R12 SS good",           3'd4, 16'h0050, 8'h93);
        check("R12 inhibit set", 32'(irq_inhibit), 1);
        insn_retire = 1'b1; @(negedge clk); insn_retire = 1'b0;
        check("R12 cleared by retire", 32'(irq_inhibit), 0);
        issue("R12 SS good again",     3'd4, 16'h0058, 8'h93);
        exc_taken = 1'b1; @(negedge clk); exc_taken = 1'b0;
        check("R12 cleared by exception", 32'(irq_inhibit), 0);

        long_mode = 1'b1;
        issue("R11 long DS",           3'd0, 16'h0010, 8'h93);
        issue("R11 long SS",           3'd4, 16'h0050, 8'h93);
        issue("R11 long FS ok",        3'd2, 16'h0060, 8'h93);
        long_mode = 1'b0;

        // R2: second request held during evaluation is dropped
        begin
            item_t it;
            logic [7:0] wa;
            predict(3'd1, 16'h0068, 8'h93, it.flt, it.err, wa);
            it.dst = 3'd1;
            m_sel[1] = 16'h0068; m_attr[1] = wa;
            q_item.push_back(it); q_tag.push_back("R2 overlap first");
            @(negedge clk);
            load_dst = 3'd1; load_sel = 16'h0068; load_attr = 8'h93; load_req = 1'b1;
            @(negedge clk);
            load_sel = 16'h0070;
            @(negedge clk);
            load_req = 1'b0;
            repeat (4) @(negedge clk);
            rd_dst = 3'd1; #1;
            check("R2 overlap dropped", 32'(rd_sel), 32'h0068);
            check("R2 queue drained", 32'(q_item.size()), 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule